// File: doc/BRIEF.md
# Two-Thread L1 Tag Sharing Controller

This block owns the tag side of a small set-associative L1 data cache used by two hardware threads of one core. Each thread presents an address-space context: a page-table root value and a paging-mode code. From those contexts and one global mode bit, the controller decides whether a tag match ignores the requesting thread or includes it. It then looks up, fills and evicts tag lines on that basis.

Lookups arrive on a valid/ready request channel that carries a thread, a set index, a linear tag and the physical tag of the requester's translation. Exactly one response follows each accepted request on a valid/ready response channel. The response reports hit or miss and the way that was hit or filled. On a miss that displaced a line, it also reports that line's thread, linear tag and physical tag, so that the surrounding cache can write it back or drop it.

There are three sharing states: adaptive with matching contexts, adaptive with differing contexts, and forced-shared. Whenever the sharing state changes, every line is invalidated in a single cycle.

Back-pressure rules: a request is taken on a rising edge where req_valid and req_ready are both high. The response appears in the following cycle and stays unchanged until it is taken with resp_ready. req_ready is low while an untaken response is pending and during the invalidation cycle.

Top module: `l1s_share_top`

## Requirements
- R1: After reset, resp_valid is 0, req_ready is 1 when both contexts are equal and mode is 0, and every line is invalid, so the first lookup misses with resp_evict 0.
- R2: With shared_mode_i 0 and both page-table roots and paging modes equal, the thread is ignored in matching: a line filled by one thread hits for the other thread when the linear and physical tags are equal.
- R3: With shared_mode_i 0 and the roots or paging modes different, the thread is part of the match, and a lookup never hits a line owned by the other thread.
- R4: With shared_mode_i 0, a set never holds two valid lines with the same linear tag. A miss whose linear tag matches a valid line of either thread replaces that line and reports it as evicted.
- R5: With shared_mode_i 1, the thread is part of the match even when both contexts are identical.
- R6: With shared_mode_i 1, lines of different threads with the same linear tag and different physical tags coexist, and each line keeps hitting for its own thread.
- R7: With shared_mode_i 1, a lookup whose linear tag matches a line of the same thread but whose physical tag differs misses. It evicts that line, refills the same way, and raises resp_thrash.
- R8: Any change of the sharing state (mode bit, or equality of the contexts while in mode 0) invalidates all lines at the next rising edge. req_ready is 0 in the cycle before that edge.
- R9: The way filled on a miss is, in order of preference, the line being replaced under R4 or R7, then the lowest-numbered invalid way, then the set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, only when it is used.
- R10: A response appears in the cycle after acceptance. It holds all fields stable while resp_ready is 0, and req_ready stays 0 until the response is taken.
- R11: A hit reports resp_hit 1 with the matching way, changes no line, and reports resp_evict 0 with zeroed eviction fields. A miss without a displaced valid line reports resp_evict 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shared_mode_i | input | 1 | 0 selects adaptive sharing, 1 selects forced-shared |
| t0_root_i | input | 40 | Page-table root of thread 0 |
| t0_pgmode_i | input | 3 | Paging-mode code of thread 0 |
| t1_root_i | input | 40 | Page-table root of thread 1 |
| t1_pgmode_i | input | 3 | Paging-mode code of thread 1 |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_thread | input | 1 | Requesting thread |
| req_set | input | 4 | Set index |
| req_ltag | input | 20 | Linear tag |
| req_ptag | input | 24 | Physical tag of the requester's translation |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response taken |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 2 | Way hit or filled |
| resp_thrash | output | 1 | Same-thread physical mismatch resolved in forced-shared state |
| resp_evict | output | 1 | A valid line was displaced |
| resp_ev_thread | output | 1 | Thread of the displaced line |
| resp_ev_ltag | output | 20 | Linear tag of the displaced line |
| resp_ev_ptag | output | 24 | Physical tag of the displaced line |

## Verification
The assertions assume that the tag store starts empty and is only written through misses. From that they take for granted that no two lines in a set match the same lookup, and that no linear-tag alias exists outside the forced-shared state. They also assume that resp_ready eventually rises, so that a held response and a low req_ready are legal states and not a deadlock. The stimulus changes contexts only at negative clock edges, draws linear and physical tags from small pools so that aliases and conflicts actually occur, and lowers resp_ready only in a directed back-pressure step that later releases it.

// File: rtl/l1s_pkg.sv
package l1s_pkg;
  parameter int LTAG_W = 20;
  parameter int PTAG_W = 24;
  parameter int ROOT_W = 40;
  parameter int PGM_W  = 3;

  typedef struct packed {
    logic              valid;
    logic              thr;
    logic [LTAG_W-1:0] ltag;
    logic [PTAG_W-1:0] ptag;
  } line_t;

  typedef enum logic [1:0] {
    SH_COMMON = 2'd0,
    SH_SPLIT  = 2'd1,
    SH_FORCED = 2'd2
  } share_e;
endpackage

// File: rtl/l1s_share_decide.sv
module l1s_share_decide
  import l1s_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [ROOT_W-1:0] root0_i,
  input  logic [PGM_W-1:0]  pgm0_i,
  input  logic [ROOT_W-1:0] root1_i,
  input  logic [PGM_W-1:0]  pgm1_i,
  output share_e            state_o,
  output logic              flush_o
);
  share_e nxt;
  share_e state_q;

  always_comb begin
    if (mode_i)
      nxt = SH_FORCED;
    else if ((root0_i == root1_i) && (pgm0_i == pgm1_i))
      nxt = SH_COMMON;
    else
      nxt = SH_SPLIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SH_COMMON;
    else        state_q <= nxt;
  end

  assign state_o = state_q;
  assign flush_o = (nxt != state_q);

  AST_FORCED_WHEN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && mode_i) |-> (state_o == SH_FORCED)); // R5
  AST_SPLIT_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && !mode_i && (root0_i != root1_i)) |-> (state_o == SH_SPLIT)); // R3
endmodule

// File: rtl/l1s_way_cmp.sv
module l1s_way_cmp
  import l1s_pkg::*;
(
  input  line_t             line_i,
  input  share_e            state_i,
  input  logic              thr_i,
  input  logic [LTAG_W-1:0] ltag_i,
  input  logic [PTAG_W-1:0] ptag_i,
  output logic              hit_o,
  output logic              conflict_o,
  output logic              alias_o
);
  logic lt_eq;
  logic pt_eq;
  logic thr_eq;

  always_comb begin
    lt_eq  = line_i.valid && (line_i.ltag == ltag_i);
    pt_eq  = (line_i.ptag == ptag_i);
    thr_eq = (line_i.thr == thr_i);
    hit_o  = lt_eq && pt_eq && ((state_i == SH_COMMON) || thr_eq);
    if (state_i == SH_FORCED)
      conflict_o = lt_eq && thr_eq && !pt_eq;
    else
      conflict_o = lt_eq && !hit_o;
    alias_o = lt_eq;
  end
endmodule

// File: rtl/l1s_victim_sel.sv
module l1s_victim_sel #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  conflict_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             use_ptr_o
);
  always_comb begin
    logic found;
    found     = 1'b0;
    way_o     = ptr_i;
    use_ptr_o = 1'b1;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && conflict_i[i]) begin
        found = 1'b1;
        way_o = WAY_W'(i);
      end
    end
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_i[i]) begin
        found = 1'b1;
        way_o = WAY_W'(i);
      end
    end
    if (found) use_ptr_o = 1'b0;
  end
endmodule

// File: rtl/l1s_tag_store.sv
module l1s_tag_store
  import l1s_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic [SET_W-1:0]      rd_set_i,
  output line_t [WAYS-1:0]      rd_lines_o,
  output logic [WAY_W-1:0]      rd_ptr_o,
  input  logic                  wr_en_i,
  input  logic [SET_W-1:0]      wr_set_i,
  input  logic [WAY_W-1:0]      wr_way_i,
  input  line_t                 wr_line_i,
  input  logic                  ptr_adv_i
);
  line_t [WAYS-1:0] mem   [SETS];
  logic [WAY_W-1:0] ptr_q [SETS];
  logic             any_valid;

  assign rd_lines_o = mem[rd_set_i];
  assign rd_ptr_o   = ptr_q[rd_set_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        mem[s]   <= '0;
        ptr_q[s] <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem[s][w].valid <= 1'b0;
    end else if (wr_en_i) begin
      mem[wr_set_i][wr_way_i] <= wr_line_i;
      if (ptr_adv_i) ptr_q[wr_set_i] <= ptr_q[wr_set_i] + 1'b1;
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        any_valid = any_valid | mem[s][w].valid;
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !any_valid); // R8
endmodule

// File: rtl/l1s_share_top.sv
module l1s_share_top
  import l1s_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shared_mode_i,
  input  logic [ROOT_W-1:0] t0_root_i,
  input  logic [PGM_W-1:0]  t0_pgmode_i,
  input  logic [ROOT_W-1:0] t1_root_i,
  input  logic [PGM_W-1:0]  t1_pgmode_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_thread,
  input  logic [SET_W-1:0]  req_set,
  input  logic [LTAG_W-1:0] req_ltag,
  input  logic [PTAG_W-1:0] req_ptag,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic              resp_thrash,
  output logic              resp_evict,
  output logic              resp_ev_thread,
  output logic [LTAG_W-1:0] resp_ev_ltag,
  output logic [PTAG_W-1:0] resp_ev_ptag
);
  share_e           state;
  logic             flush;
  line_t [WAYS-1:0] rd_lines;
  logic [WAY_W-1:0] rd_ptr;
  logic [WAYS-1:0]  hit_vec, conf_vec, alias_vec, valid_vec;
  logic [WAY_W-1:0] fill_way, hit_way;
  logic             use_ptr, hit_any, accept, wr_en, thrash;
  line_t            victim, wr_line;

  l1s_share_decide u_decide (
    .clk(clk), .rst_n(rst_n), .mode_i(shared_mode_i),
    .root0_i(t0_root_i), .pgm0_i(t0_pgmode_i),
    .root1_i(t1_root_i), .pgm1_i(t1_pgmode_i),
    .state_o(state), .flush_o(flush)
  );

  l1s_tag_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .rd_set_i(req_set), .rd_lines_o(rd_lines), .rd_ptr_o(rd_ptr),
    .wr_en_i(wr_en), .wr_set_i(req_set), .wr_way_i(fill_way),
    .wr_line_i(wr_line), .ptr_adv_i(use_ptr)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    l1s_way_cmp u_cmp (
      .line_i(rd_lines[w]), .state_i(state), .thr_i(req_thread),
      .ltag_i(req_ltag), .ptag_i(req_ptag),
      .hit_o(hit_vec[w]), .conflict_o(conf_vec[w]), .alias_o(alias_vec[w])
    );
    assign valid_vec[w] = rd_lines[w].valid;
  end

  l1s_victim_sel #(.WAYS(WAYS)) u_victim (
    .conflict_i(conf_vec), .valid_i(valid_vec), .ptr_i(rd_ptr),
    .way_o(fill_way), .use_ptr_o(use_ptr)
  );

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_vec[i]) hit_way = WAY_W'(i);
  end

  assign hit_any   = |hit_vec;
  assign req_ready = !flush && (!resp_valid || resp_ready);
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && !hit_any;
  assign victim    = rd_lines[fill_way];
  assign thrash    = (state == SH_FORCED) && (|conf_vec);

  always_comb begin
    wr_line       = '0;
    wr_line.valid = 1'b1;
    wr_line.thr   = req_thread;
    wr_line.ltag  = req_ltag;
    wr_line.ptag  = req_ptag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_hit       <= 1'b0;
      resp_way       <= '0;
      resp_thrash    <= 1'b0;
      resp_evict     <= 1'b0;
      resp_ev_thread <= 1'b0;
      resp_ev_ltag   <= '0;
      resp_ev_ptag   <= '0;
    end else if (accept) begin
      resp_valid     <= 1'b1;
      resp_hit       <= hit_any;
      resp_way       <= hit_any ? hit_way : fill_way;
      resp_thrash    <= !hit_any && thrash;
      resp_evict     <= !hit_any && victim.valid;
      resp_ev_thread <= (!hit_any && victim.valid) ? victim.thr  : 1'b0;
      resp_ev_ltag   <= (!hit_any && victim.valid) ? victim.ltag : '0;
      resp_ev_ptag   <= (!hit_any && victim.valid) ? victim.ptag : '0;
    end else if (resp_ready) begin
      resp_valid     <= 1'b0;
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $onehot0(hit_vec)); // R11
  AST_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (state != SH_FORCED)) |-> ($countones(alias_vec) <= 1)); // R4
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit) && $stable(resp_way)
                                     && $stable(resp_evict))); // R10
  AST_THRASH_EVICTS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_thrash) |-> (resp_evict && !resp_hit)); // R7
  AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !resp_evict); // R11
endmodule

// File: tb/l1s_share_top_tb.sv
`timescale 1ns/1ps
module l1s_share_top_tb;
  import l1s_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              shared_mode_i = 1'b0;
  logic [ROOT_W-1:0] t0_root_i = '0, t1_root_i = '0;
  logic [PGM_W-1:0]  t0_pgmode_i = '0, t1_pgmode_i = '0;
  logic              req_valid = 1'b0, req_thread = 1'b0, resp_ready = 1'b1;
  logic [3:0]        req_set = '0;
  logic [LTAG_W-1:0] req_ltag = '0;
  logic [PTAG_W-1:0] req_ptag = '0;
  logic              req_ready, resp_valid, resp_hit, resp_thrash, resp_evict, resp_ev_thread;
  logic [1:0]        resp_way;
  logic [LTAG_W-1:0] resp_ev_ltag;
  logic [PTAG_W-1:0] resp_ev_ptag;

  l1s_share_top u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference tag store
  bit                m_v [16][4];
  bit                m_t [16][4];
  logic [LTAG_W-1:0] m_l [16][4];
  logic [PTAG_W-1:0] m_p [16][4];
  int                m_ptr [16];
  int                m_st = 0;   // 0 common, 1 split, 2 forced

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int calc_state();
    if (shared_mode_i) return 2;
    if (t0_root_i == t1_root_i && t0_pgmode_i == t1_pgmode_i) return 0;
    return 1;
  endfunction

  task automatic set_ctx(bit md, logic [ROOT_W-1:0] r0, logic [PGM_W-1:0] g0,
                         logic [ROOT_W-1:0] r1, logic [PGM_W-1:0] g1);
    int ns;
    @(negedge clk);
    shared_mode_i = md; t0_root_i = r0; t0_pgmode_i = g0; t1_root_i = r1; t1_pgmode_i = g1;
    ns = calc_state();
    #1;
    if (ns != m_st) begin
      chk(req_ready == 1'b0, "R8 ready low on state change", 64'(req_ready), 64'd0);
      for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_v[s][w] = 0;
      m_st = ns;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready back after flush", 64'(req_ready), 64'd1);
  endtask

  // exp_hit: -1 no explicit check
  task automatic do_req(bit thr, int set, logic [LTAG_W-1:0] lt, logic [PTAG_W-1:0] pt,
                        string tag, int exp_hit);
    bit h = 0, conf_found = 0, inv_found = 0, ev = 0, th = 0;
    int way = 0;
    logic [50:0] e, a;
    for (int w = 0; w < 4; w++)
      if (m_v[set][w] && m_l[set][w] == lt && m_p[set][w] == pt && (m_st == 0 || m_t[set][w] == thr)) begin
        h = 1; way = w;
      end
    if (!h) begin
      for (int w = 0; w < 4; w++) begin
        bit c;
        if (m_st == 2) c = m_v[set][w] && m_l[set][w] == lt && m_t[set][w] == thr && m_p[set][w] != pt;
        else           c = m_v[set][w] && m_l[set][w] == lt;
        if (c && !conf_found) begin conf_found = 1; way = w; th = (m_st == 2); end
      end
      if (!conf_found)
        for (int w = 0; w < 4; w++)
          if (!m_v[set][w] && !inv_found) begin inv_found = 1; way = w; end
      if (!conf_found && !inv_found) begin way = m_ptr[set]; m_ptr[set] = (m_ptr[set] + 1) % 4; end
      ev = m_v[set][way];
      e = {1'b1, 1'b0, 2'(way), th, ev, ev ? m_t[set][way] : 1'b0,
           ev ? m_l[set][way] : LTAG_W'(0), ev ? m_p[set][way] : PTAG_W'(0)};
      m_v[set][way] = 1; m_t[set][way] = thr; m_l[set][way] = lt; m_p[set][way] = pt;
    end else begin
      e = {1'b1, 1'b1, 2'(way), 1'b0, 1'b0, 1'b0, LTAG_W'(0), PTAG_W'(0)};
    end
    @(negedge clk);
    req_valid = 1; req_thread = thr; req_set = 4'(set); req_ltag = lt; req_ptag = pt;
    @(negedge clk);
    req_valid = 0;
    a = {resp_valid, resp_hit, resp_way, resp_thrash, resp_evict, resp_ev_thread, resp_ev_ltag, resp_ev_ptag};
    chk(a == e, tag, 64'(a), 64'(e));
    if (exp_hit >= 0)
      chk(resp_hit == exp_hit[0], tag, 64'(resp_hit), 64'(exp_hit));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [50:0] hold;
    int dummy;
    dummy = $urandom(32'h5EED_1234);
    for (int s = 0; s < 16; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    end
    t0_root_i = 40'h123; t1_root_i = 40'h123; t0_pgmode_i = 3'd1; t1_pgmode_i = 3'd1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(resp_valid == 0, "R1 resp_valid after reset", 64'(resp_valid), 64'd0);
    chk(req_ready == 1, "R1 req_ready after reset", 64'(req_ready), 64'd1);

    do_req(0, 5, 20'hA, 24'h55, "R1 first lookup misses", 0);
    do_req(1, 5, 20'hA, 24'h55, "R2 other thread hits common line", 1);

    set_ctx(0, 40'h123, 3'd1, 40'h124, 3'd1);
    do_req(0, 5, 20'hA, 24'h55, "R8 lines cleared by state change", 0);
    do_req(1, 5, 20'hB, 24'h66, "R3 thread 1 fill", 0);
    do_req(0, 5, 20'hB, 24'h66, "R3 other thread never hits", 0);
    do_req(1, 5, 20'hA, 24'h55, "R4 alias replaced across threads", 0);
    do_req(1, 5, 20'hA, 24'h55, "R11 hit after alias fill", 1);

    set_ctx(0, 40'h123, 3'd1, 40'h123, 3'd2);
    do_req(0, 6, 20'hC, 24'h1, "R3 pgmode differs fill", 0);
    do_req(1, 6, 20'hC, 24'h1, "R4 alias split state", 0);

    set_ctx(1, 40'h123, 3'd1, 40'h123, 3'd1);
    do_req(0, 5, 20'hC, 24'h1, "R5 forced fill", 0);
    do_req(1, 5, 20'hC, 24'h1, "R5 identical ctx still per thread", 0);
    do_req(0, 5, 20'hC, 24'h2, "R7 thrash same thread", 0);
    do_req(1, 5, 20'hC, 24'h3, "R6 alias other thread coexists", 0);
    do_req(0, 5, 20'hC, 24'h2, "R6 thread 0 keeps hitting", 1);
    do_req(1, 5, 20'hC, 24'h3, "R6 thread 1 keeps hitting", 1);

    for (int i = 0; i < 6; i++)
      do_req(0, 7, LTAG_W'(16 + i), 24'h9, "R9 fill order", 0);

    @(negedge clk); resp_ready = 0;
    do_req(1, 8, 20'h77, 24'h7, "R10 response under backpressure", 0);
    hold = {resp_valid, resp_hit, resp_way, resp_thrash, resp_evict, resp_ev_thread, resp_ev_ltag, resp_ev_ptag};
    chk(req_ready == 0, "R10 ready low while pending", 64'(req_ready), 64'd0);
    @(negedge clk); @(negedge clk);
    chk({resp_valid, resp_hit, resp_way, resp_thrash, resp_evict, resp_ev_thread, resp_ev_ltag, resp_ev_ptag} == hold,
        "R10 response held", 64'({resp_valid, resp_hit, resp_way}), 64'(hold[50:47]));
    resp_ready = 1;
    @(negedge clk);
    chk(resp_valid == 0, "R10 response taken", 64'(resp_valid), 64'd0);

    for (int i = 0; i < 3000; i++) begin
      if (i % 150 == 0)
        set_ctx(1'($urandom_range(0, 2) == 0), ROOT_W'($urandom_range(0, 1)), PGM_W'($urandom_range(0, 1)),
                ROOT_W'($urandom_range(0, 1)), PGM_W'($urandom_range(0, 1)));
      do_req(1'($urandom_range(0, 1)), $urandom_range(0, 3), LTAG_W'($urandom_range(0, 5)),
             PTAG_W'($urandom_range(0, 1)), "R11 random lookup", -1);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule